// File: doc/BRIEF.md
# Nibble-Serial Instruction Sequencer

This block is the front end of a small 4-bit controller. It reads program memory one nibble per clock through a 12-bit address. It decides from the first nibble how many nibbles the instruction holds and packs them into a left-aligned instruction word. Each instruction class occupies a fixed number of clock cycles. When an instruction's last cycle ends, the block raises a one-cycle execute strobe and presents the packed word and its length to the datapath, which lies outside this block.

The sequencer resolves all control flow on its own. It handles a jump taken on carry, a jump taken on zero, an unconditional jump, a subroutine call that saves its return address in a four-entry hardware stack, and a return that takes the address back from that stack. Carry and zero arrive as inputs from the datapath and are sampled during the last cycle of a conditional jump.

Top module: `nibble_sequencer`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `mem_addr` is 0x000, `exec_strobe` is 0 and `instr_word` and `instr_len` are 0.
- R2: A first nibble of 0xF gives a 5-nibble instruction and 0xE gives a 3-nibble one. Any other first nibble gives a 2-nibble instruction. On the strobe, `instr_len` holds the count and `instr_word` holds nibble k at bits [19-4k -: 4], so the first nibble is at [19:16] and unused low nibbles are zero.
- R3: An instruction takes a fixed number of cycles from its first fetch to the first fetch of its successor. The counts are: 2 for a plain 2-nibble instruction, 5 for return (0x9 0xF), 3 for a plain 3-nibble instruction, 4 for port write (0xE 0xC), 6 for any 5-nibble instruction other than call, and 9 for call (0xF 0xF). `exec_strobe` is high in the first cycle after the last one.
- R4: In each fetch cycle the address advances by one. In the remaining cycles of an instruction it holds. Apart from branch targets, the address only steps by one, wrapping from 0xFFF to 0x000.
- R5: Jump-on-carry (0xF 0xC t2 t1 t0) loads the 12-bit target t2t1t0 (most significant nibble first) when `carry_in` is high in its last cycle. Otherwise the next fetch is the nibble after the instruction.
- R6: Jump-on-zero (0xF 0xD t2 t1 t0) behaves the same way, but tests `zero_in`.
- R7: The unconditional jump (0xF 0xE t2 t1 t0) always continues at the target.
- R8: Call (0xF 0xF t2 t1 t0) pushes the address of the nibble after the call and continues at the target.
- R9: Return (0x9 0xF) continues at the most recently pushed address and removes it from the stack.
- R10: The stack holds 4 return addresses. A fifth push discards the oldest entry, so later returns give back the 4 newest in last-in-first-out order.
- R11: A return with an empty stack continues at address 0x000.
- R12: `exec_strobe` is never high in two consecutive cycles. `instr_word` changes only in a strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Program memory nibble address (registered) |
| mem_data | input | 4 | Nibble at `mem_addr`, valid in the same cycle |
| carry_in | input | 1 | Carry flag from the datapath |
| zero_in | input | 1 | Zero flag from the datapath |
| exec_strobe | output | 1 | One-cycle pulse: a packed instruction is ready |
| instr_word | output | 20 | Packed instruction, first nibble in the top bits |
| instr_len | output | 3 | Nibble count of the packed instruction |

## Verification
The properties assume three things about the inputs. First, `mem_data` is a pure function of `mem_addr` that is settled within the same cycle. Second, the flag inputs are stable across each rising edge. Third, reset is high from time zero. The bench models program memory as a combinational lookup indexed by the address. It changes the flags only on falling edges, from a free-running LFSR, and it asserts reset before the first edge. The test program is laid out so that both outcomes of each conditional jump, a call chain deep enough to overflow the stack, a return with an empty stack, and an address wrap through 0xFFF all occur during the run.

// File: rtl/nibble_seq_pkg.sv
package nibble_seq_pkg;

  typedef enum logic [2:0] {
    K_SEQ,
    K_JC,
    K_JZ,
    K_JU,
    K_CALL,
    K_RET
  } kind_t;

  // leading and second nibbles that select a class
  localparam logic [3:0] LEAD_LONG = 4'hF;
  localparam logic [3:0] LEAD_MID  = 4'hE;
  localparam logic [3:0] LEAD_RET  = 4'h9;
  localparam logic [3:0] SUB_JC    = 4'hC;
  localparam logic [3:0] SUB_JZ    = 4'hD;
  localparam logic [3:0] SUB_JU    = 4'hE;
  localparam logic [3:0] SUB_CALL  = 4'hF;
  localparam logic [3:0] SUB_PORT  = 4'hC;
  localparam logic [3:0] SUB_RET   = 4'hF;

  // nibble counts per length class
  localparam int NIBS_SHORT = 2;
  localparam int NIBS_MID   = 3;
  localparam int NIBS_LONG  = 5;

  // cycle budgets per instruction class
  localparam int CYC_SHORT = 2;
  localparam int CYC_MID   = 3;
  localparam int CYC_PORT  = 4;
  localparam int CYC_RET   = 5;
  localparam int CYC_JUMP  = 6;
  localparam int CYC_CALL  = 9;

endpackage

// File: rtl/nibble_seq_decode.sv
module nibble_seq_decode
  import nibble_seq_pkg::*;
#(
  parameter int CYC_W = 4
) (
  input  logic [3:0]       lead,
  input  logic [3:0]       sub,
  output logic [2:0]       nibs,
  output logic [CYC_W-1:0] cycles,
  output kind_t            kind
);

  always_comb begin
    kind = K_SEQ;
    if (lead == LEAD_LONG) begin
      nibs   = 3'(NIBS_LONG);
      cycles = CYC_W'(CYC_JUMP);
      unique case (sub)
        SUB_JC:   kind = K_JC;
        SUB_JZ:   kind = K_JZ;
        SUB_JU:   kind = K_JU;
        SUB_CALL: begin
          kind   = K_CALL;
          cycles = CYC_W'(CYC_CALL);
        end
        default:  kind = K_SEQ;
      endcase
    end else if (lead == LEAD_MID) begin
      nibs   = 3'(NIBS_MID);
      cycles = (sub == SUB_PORT) ? CYC_W'(CYC_PORT) : CYC_W'(CYC_MID);
    end else begin
      nibs = 3'(NIBS_SHORT);
      if (lead == LEAD_RET && sub == SUB_RET) begin
        kind   = K_RET;
        cycles = CYC_W'(CYC_RET);
      end else begin
        cycles = CYC_W'(CYC_SHORT);
      end
    end
  end

endmodule

// File: rtl/nibble_seq_stack.sv
module nibble_seq_stack #(
  parameter int DEPTH = 4,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_addr,
  output logic [AW-1:0] top_addr
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] slots [DEPTH];
  logic [PW-1:0] top_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] up_idx;
  logic [PW-1:0] dn_idx;

  assign up_idx   = (top_q == PW'(DEPTH - 1)) ? '0 : top_q + PW'(1);
  assign dn_idx   = (top_q == '0) ? PW'(DEPTH - 1) : top_q - PW'(1);
  assign top_addr = (cnt_q == '0) ? '0 : slots[top_q];

  // storage without reset so it maps onto plain RAM bits
  always_ff @(posedge clk) begin
    if (push) slots[up_idx] <= push_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      top_q <= PW'(DEPTH - 1);
      cnt_q <= '0;
    end else if (push) begin
      top_q <= up_idx;
      if (cnt_q != CW'(DEPTH)) cnt_q <= cnt_q + CW'(1);
    end else if (pop && cnt_q != '0) begin
      top_q <= dn_idx;
      cnt_q <= cnt_q - CW'(1);
    end
  end

endmodule

// File: rtl/nibble_sequencer.sv
module nibble_sequencer
  import nibble_seq_pkg::*;
#(
  parameter int PC_W      = 12,
  parameter int STK_DEPTH = 4,
  parameter int MAX_NIBS  = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  output logic [PC_W-1:0]       mem_addr,
  input  logic [3:0]            mem_data,
  input  logic                  carry_in,
  input  logic                  zero_in,
  output logic                  exec_strobe,
  output logic [4*MAX_NIBS-1:0] instr_word,
  output logic [2:0]            instr_len
);

  localparam int WORD_W = 4 * MAX_NIBS;
  localparam int CYC_W  = $clog2(CYC_CALL + 1);

  logic [PC_W-1:0]   pc_q, pc_seq, pc_d;
  logic [CYC_W-1:0]  cyc_q, tot_q, cur_tot, d_cycles;
  logic [3:0]        lead_q, dec_lead;
  logic [2:0]        nibs_q, cur_nibs, d_nibs;
  kind_t             kind_q, cur_kind, d_kind;
  logic [WORD_W-1:0] word_q, word_cur;
  logic              fetching, last;
  logic              push, pop;
  logic [PC_W-1:0]   stk_top;

  assign dec_lead = (cyc_q == '0) ? mem_data : lead_q;

  nibble_seq_decode #(.CYC_W(CYC_W)) u_decode (
    .lead   (dec_lead),
    .sub    (mem_data),
    .nibs   (d_nibs),
    .cycles (d_cycles),
    .kind   (d_kind)
  );

  assign cur_nibs = (cyc_q == '0) ? d_nibs : nibs_q;
  assign cur_tot  = (cyc_q == CYC_W'(1)) ? d_cycles : tot_q;
  assign cur_kind = (cyc_q == CYC_W'(1)) ? d_kind : kind_q;
  assign fetching = cyc_q < CYC_W'(cur_nibs);
  assign last     = (cyc_q != '0) && (cyc_q + CYC_W'(1) == cur_tot);

  // drop the incoming nibble into its slot, first nibble on top
  always_comb begin
    word_cur = (cyc_q == '0) ? '0 : word_q;
    for (int k = 0; k < MAX_NIBS; k++) begin
      if (fetching && cyc_q == CYC_W'(k))
        word_cur[WORD_W-1-4*k -: 4] = mem_data;
    end
  end

  assign pc_seq = fetching ? pc_q + PC_W'(1) : pc_q;

  always_comb begin
    pc_d = pc_seq;
    push = 1'b0;
    pop  = 1'b0;
    if (last) begin
      unique case (cur_kind)
        K_JC:   if (carry_in) pc_d = word_cur[PC_W-1:0];
        K_JZ:   if (zero_in)  pc_d = word_cur[PC_W-1:0];
        K_JU:   pc_d = word_cur[PC_W-1:0];
        K_CALL: begin
          pc_d = word_cur[PC_W-1:0];
          push = 1'b1;
        end
        K_RET:  begin
          pc_d = stk_top;
          pop  = 1'b1;
        end
        default: pc_d = pc_seq;
      endcase
    end
  end

  nibble_seq_stack #(.DEPTH(STK_DEPTH), .AW(PC_W)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .pop       (pop),
    .push_addr (pc_seq),
    .top_addr  (stk_top)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q        <= '0;
      cyc_q       <= '0;
      lead_q      <= '0;
      nibs_q      <= '0;
      tot_q       <= '0;
      kind_q      <= K_SEQ;
      word_q      <= '0;
      exec_strobe <= 1'b0;
      instr_word  <= '0;
      instr_len   <= '0;
    end else begin
      pc_q        <= pc_d;
      word_q      <= word_cur;
      exec_strobe <= last;
      cyc_q       <= last ? '0 : cyc_q + CYC_W'(1);
      if (cyc_q == '0) begin
        lead_q <= mem_data;
        nibs_q <= d_nibs;
      end
      if (cyc_q == CYC_W'(1)) begin
        tot_q  <= d_cycles;
        kind_q <= d_kind;
      end
      if (last) begin
        instr_word <= word_cur;
        instr_len  <= cur_nibs;
      end
    end
  end

  assign mem_addr = pc_q;

endmodule

// File: rtl/nibble_sequencer_chk.sv
module nibble_sequencer_chk #(
  parameter int PC_W   = 12,
  parameter int WORD_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic [PC_W-1:0]   mem_addr,
  input logic              carry_in,
  input logic              zero_in,
  input logic              exec_strobe,
  input logic [WORD_W-1:0] instr_word,
  input logic [2:0]        instr_len
);

  p_len_legal_r2: assert property (@(posedge clk) disable iff (rst)
    exec_strobe |-> (instr_len == 3'd2 || instr_len == 3'd3 || instr_len == 3'd5));

  p_strobe_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    exec_strobe |=> !exec_strobe);

  p_word_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !exec_strobe |-> $stable(instr_word));

  p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
    !exec_strobe |-> (mem_addr == $past(mem_addr) || mem_addr == $past(mem_addr) + PC_W'(1)));

  p_jc_taken_r5: assert property (@(posedge clk) disable iff (rst)
    (exec_strobe && instr_word[WORD_W-1 -: 8] == 8'hFC && $past(carry_in))
      |-> mem_addr == instr_word[PC_W-1:0]);

  p_jz_taken_r6: assert property (@(posedge clk) disable iff (rst)
    (exec_strobe && instr_word[WORD_W-1 -: 8] == 8'hFD && $past(zero_in))
      |-> mem_addr == instr_word[PC_W-1:0]);

  p_jun_r7: assert property (@(posedge clk) disable iff (rst)
    (exec_strobe && instr_word[WORD_W-1 -: 8] == 8'hFE) |-> mem_addr == instr_word[PC_W-1:0]);

  p_call_r8: assert property (@(posedge clk) disable iff (rst)
    (exec_strobe && instr_word[WORD_W-1 -: 8] == 8'hFF) |-> mem_addr == instr_word[PC_W-1:0]);

endmodule

bind nibble_sequencer nibble_sequencer_chk #(
  .PC_W   (PC_W),
  .WORD_W (4 * MAX_NIBS)
) i_chk (
  .clk         (clk),
  .rst         (rst),
  .mem_addr    (mem_addr),
  .carry_in    (carry_in),
  .zero_in     (zero_in),
  .exec_strobe (exec_strobe),
  .instr_word  (instr_word),
  .instr_len   (instr_len)
);

// File: tb/test_nibble_sequencer.sv
module test_nibble_sequencer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic [3:0]  mem_data;
  logic        carry_in = 1'b0;
  logic        zero_in  = 1'b0;
  logic        exec_strobe;
  logic [19:0] instr_word;
  logic [2:0]  instr_len;

  logic [3:0]  prog [256];
  int checks = 0;
  int errors = 0;

  // reference model state
  int          m_pc;
  int          m_len;
  logic [19:0] m_word;
  int          aq[$];
  int          stk[$];
  bit          ovf;
  bit          exp_strobe;
  logic [19:0] exp_word;
  logic [19:0] last_word;
  int          exp_len;
  string       next_tag;
  logic [15:0] lfsr;

  always #5 clk = ~clk;

  assign mem_data = prog[mem_addr[7:0]];

  nibble_sequencer i_nibble_sequencer (
    .clk         (clk),
    .rst         (rst),
    .mem_addr    (mem_addr),
    .mem_data    (mem_data),
    .carry_in    (carry_in),
    .zero_in     (zero_in),
    .exec_strobe (exec_strobe),
    .instr_word  (instr_word),
    .instr_len   (instr_len)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic place(input int a, input logic [19:0] nibs, input int n);
    for (int k = 0; k < n; k++) prog[(a + k) & 255] = nibs[19-4*k -: 4];
  endtask

  function automatic logic [3:0] rd(input int a);
    return prog[a & 255];
  endfunction

  task automatic step();
    string tag;
    int    expa;
    int    fall;
    int    tgt;
    bit    first_cyc;
    first_cyc = 0;
    if (aq.size() == 0) begin
      logic [3:0] f, s;
      int cyc_n;
      f = rd(m_pc);
      s = rd(m_pc + 1);
      m_len = (f == 4'hF) ? 5 : (f == 4'hE) ? 3 : 2;
      if (m_len == 5)      cyc_n = (s == 4'hF) ? 9 : 6;
      else if (m_len == 3) cyc_n = (s == 4'hC) ? 4 : 3;
      else                 cyc_n = (f == 4'h9 && s == 4'hF) ? 5 : 2;
      m_word = '0;
      for (int k = 0; k < m_len; k++) m_word[19-4*k -: 4] = rd(m_pc + k);
      for (int k = 0; k < cyc_n; k++) aq.push_back((m_pc + ((k < m_len) ? k : m_len)) % 4096);
      first_cyc = 1;
    end
    tag  = first_cyc ? next_tag : "R4";
    expa = aq.pop_front();
    chk(mem_addr == 12'(expa), tag, "fetch address", int'(mem_addr), expa);
    chk(exec_strobe == exp_strobe, "R3", "strobe timing", int'(exec_strobe), int'(exp_strobe));
    if (exp_strobe) begin
      chk(instr_word == exp_word, "R2", "packed word", int'(instr_word), int'(exp_word));
      chk(instr_len == 3'(exp_len), "R2", "length", int'(instr_len), exp_len);
      last_word = exp_word;
    end else begin
      chk(instr_word == last_word, "R12", "word held", int'(instr_word), int'(last_word));
    end
    exp_strobe = 0;
    lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    carry_in = lfsr[0];
    zero_in  = lfsr[5];
    if (aq.size() == 0) begin
      fall     = (m_pc + m_len) % 4096;
      tgt      = int'(m_word[11:0]);
      next_tag = "R4";
      m_pc     = fall;
      if (m_len == 5) begin
        case (m_word[15:12])
          4'hC: begin next_tag = "R5"; if (carry_in) m_pc = tgt; end
          4'hD: begin next_tag = "R6"; if (zero_in)  m_pc = tgt; end
          4'hE: begin next_tag = "R7"; m_pc = tgt; end
          4'hF: begin
            next_tag = "R8";
            stk.push_back(fall);
            if (stk.size() > 4) begin
              void'(stk.pop_front());
              ovf = 1;
            end
            m_pc = tgt;
          end
          default: ;
        endcase
      end else if (m_len == 2 && m_word[19:12] == 8'h9F) begin
        if (stk.size() == 0) begin
          next_tag = "R11";
          m_pc = 0;
        end else begin
          next_tag = ovf ? "R10" : "R9";
          m_pc = stk.pop_back();
        end
      end
      exp_strobe = 1;
      exp_word   = m_word;
      exp_len    = m_len;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) prog[i] = 4'h0;
    place(12'h000, 20'h53000, 2);
    place(12'h002, 20'hED700, 3);
    place(12'h005, 20'hEC400, 3);
    place(12'h008, 20'h9D000, 2);
    place(12'h00A, 20'hFC020, 5);
    place(12'h00F, 20'hFD030, 5);
    place(12'h014, 20'hFF040, 5);
    place(12'h019, 20'hFE0A0, 5);
    place(12'h020, 20'h00000, 2);
    place(12'h022, 20'hFEFFE, 5);
    place(12'h030, 20'h81000, 2);
    place(12'h032, 20'hFE014, 5);
    place(12'h040, 20'h9F000, 2);
    place(12'h050, 20'hFF060, 5);
    place(12'h055, 20'h9F000, 2);
    place(12'h060, 20'hFF070, 5);
    place(12'h065, 20'h9F000, 2);
    place(12'h070, 20'hFF080, 5);
    place(12'h075, 20'h9F000, 2);
    place(12'h080, 20'hFF090, 5);
    place(12'h085, 20'h9F000, 2);
    place(12'h090, 20'h9F000, 2);
    place(12'h0A0, 20'hFF050, 5);
    place(12'h0A5, 20'h9F000, 2);
    place(12'hFFE, 20'h53000, 2);

    m_pc       = 0;
    ovf        = 0;
    exp_strobe = 0;
    last_word  = '0;
    next_tag   = "R4";
    lfsr       = 16'hACE1;

    repeat (3) @(negedge clk);
    chk(mem_addr == 12'h000, "R1", "reset address", int'(mem_addr), 0);
    chk(exec_strobe == 1'b0, "R1", "reset strobe", int'(exec_strobe), 0);
    chk(instr_word == '0, "R1", "reset word", int'(instr_word), 0);
    chk(instr_len == '0, "R1", "reset length", int'(instr_len), 0);
    rst = 1'b0;

    for (int cyc = 0; cyc < 4000; cyc++) begin
      step();
      @(negedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule